// File: doc/BRIEF.md
# Snooping Coherence Controller with Hog State

This block is the coherence control for one private cache on a shared snooping bus. It runs a write-invalidate protocol with invalid, shared, exclusive and modified line states. It adds a fifth state, hog (H). A line in H grants the same local rights as modified: it is dirty and exclusive, and reads and writes complete without bus traffic. While a line is hogged, the controller refuses every request that other caches make for that block on the bus. It answers such a request with a negative acknowledge (NACK). The requester keeps its request pending and retries it on a later bus cycle. A hogged line leaves H only when its own processor self-invalidates it. That self-invalidation writes the dirty data back.

The processor side presents one command at a time: read, write, hog or self-invalidate, on one of `NBLK` tracked blocks. The command is held until `cpuDone`. When a command needs the bus, the controller raises `busReq`. The transaction happens in the cycle that an external arbiter grants it. Only one transaction runs on the bus per cycle. Each other controller sees that transaction on its snoop inputs and answers it in the same cycle. The answers are a shared line, a flush (dirty data supply) line and the NACK line. The data array, the arbiter and memory sit outside this block.

Top module: `hogSnoopCtl`

## Requirements
- R1: After reset every tracked line is invalid. With no command presented, `cpuDone` and `busReq` are low.
- R2: A read of an invalid line raises `busReq` with `busCmd`=0 (shared read) and `busBlk`=`cpuBlk`. Once granted without NACK, the line fills exclusive if `shareIn` is low and shared if it is high. A read of a line in S, E, M or H completes in the same cycle with `cpuHit` high and no bus request.
- R3: A write to an E line completes locally and makes it M. A write to an M or H line completes locally and leaves the state unchanged. A write to an I or S line requests the bus with `busCmd`=1 (ownership read) and fills M.
- R4: A hog command on an E or M line completes locally and makes it H. On an I or S line it requests the bus with `busCmd`=2 (hog read) and fills H.
- R5: A snooped shared read (`snpCmd`=0) that finds the block in S, E or M raises `shareOut`. It leaves the line in S, and it raises `flushOut` when the line was M.
- R6: A snooped ownership read or hog read (`snpCmd`=1 or 2) that finds the block in S, E or M raises `shareOut`, invalidates the line, and raises `flushOut` when the line was M.
- R7: A snooped request of any kind for a block held in H raises `nackOut` only. The line stays in H. A requester that sees `nackIn` during its granted cycle does not complete, and it requests again on later cycles.
- R8: Self-invalidate (`cpuOp`=3) completes locally and makes the line I. It raises `wbOut` in that same cycle when the line was M or H.
- R9: A command that would complete locally does not complete in a cycle when the snoop inputs carry a transaction for the same block. The snoop update takes that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuValid | input | 1 | Processor command present, held until done |
| cpuOp | input | 2 | 0 read, 1 write, 2 hog, 3 self-invalidate |
| cpuBlk | input | BW | Target block index |
| cpuDone | output | 1 | Command completes at this clock edge |
| cpuHit | output | 1 | Command completed without a bus transaction (not self-invalidate) |
| wbOut | output | 1 | Dirty line written back by self-invalidate |
| busReq | output | 1 | Bus transaction wanted |
| busCmd | output | 2 | 0 shared read, 1 ownership read, 2 hog read, 3 none |
| busBlk | output | BW | Block of the requested transaction |
| busGnt | input | 1 | This controller owns the bus this cycle |
| shareIn | input | 1 | Another cache holds a valid non-hogged copy |
| nackIn | input | 1 | Another cache hogs the block |
| snpValid | input | 1 | Another controller's transaction is on the bus |
| snpCmd | input | 2 | Snooped transaction kind, same code as busCmd |
| snpBlk | input | BW | Snooped block index |
| shareOut | output | 1 | Holds the snooped block in S, E or M |
| flushOut | output | 1 | Supplies dirty data for the snooped block |
| nackOut | output | 1 | Refuses the snooped request (block in H) |

## Verification
The bench builds three controllers, each with `NBLK`=4, on one modelled bus with a rotating grant. With only four blocks shared by three caches, random commands collide often. So refused requests and retries, same-block stalls, flushes from modified lines, and hog cycles on a block all recur many times. A directed opening walks one block through E, S, M and H and an eviction by self-invalidate. A second block checks the silent E-to-M and M-to-H moves.

// File: rtl/hogSnoopPkg.sv
package hogSnoopPkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_M = 3'd3, ST_H = 3'd4
  } lineSt_t;

  typedef enum logic [1:0] {
    OP_RD = 2'd0, OP_WR = 2'd1, OP_HOG = 2'd2, OP_INV = 2'd3
  } cpuOp_t;

  typedef enum logic [1:0] {
    BC_GETS = 2'd0, BC_GETM = 2'd1, BC_GETH = 2'd2, BC_NONE = 2'd3
  } busCmd_t;

  // strobes from control to the line-state store
  typedef struct packed {
    logic    cpuWe;
    lineSt_t cpuNext;
    logic    snpWe;
    lineSt_t snpNext;
  } stStrobe_t;
endpackage

// File: rtl/hogSnoopDp.sv
module hogSnoopDp
  import hogSnoopPkg::*;
#(
  parameter int NBLK = 4,
  parameter int BW   = $clog2(NBLK)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [BW-1:0] cpuBlk,
  input  logic [BW-1:0] snpBlk,
  input  stStrobe_t strb,
  output lineSt_t   cpuState,
  output lineSt_t   snpState
);
  lineSt_t lineQ [NBLK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NBLK; b++) lineQ[b] <= ST_I;
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (strb.snpWe && snpBlk == BW'(b))      lineQ[b] <= strb.snpNext;
        else if (strb.cpuWe && cpuBlk == BW'(b)) lineQ[b] <= strb.cpuNext;
      end
    end
  end

  assign cpuState = lineQ[cpuBlk];
  assign snpState = lineQ[snpBlk];
endmodule

// File: rtl/hogSnoopCtrl.sv
module hogSnoopCtrl
  import hogSnoopPkg::*;
(
  input  logic      cpuValid,
  input  logic [1:0] cpuOp,
  input  logic      blkMatch,
  input  lineSt_t   cpuState,
  input  logic      snpValid,
  input  logic [1:0] snpCmd,
  input  lineSt_t   snpState,
  input  logic      busGnt,
  input  logic      shareIn,
  input  logic      nackIn,
  output stStrobe_t strb,
  output logic      cpuDone,
  output logic      cpuHit,
  output logic      wbOut,
  output logic      busReq,
  output logic [1:0] busCmd,
  output logic      shareOut,
  output logic      flushOut,
  output logic      nackOut
);
  cpuOp_t  opE;
  busCmd_t cmdE;
  lineSt_t cpuNext;
  logic    needBus, localOk, busOk, snpHit, dirty;

  always_comb begin
    opE   = cpuOp_t'(cpuOp);
    dirty = (cpuState == ST_M) || (cpuState == ST_H);
    unique case (opE)
      OP_RD:  begin needBus = (cpuState == ST_I);                        cmdE = BC_GETS; end
      OP_WR:  begin needBus = (cpuState == ST_I) || (cpuState == ST_S);  cmdE = BC_GETM; end
      OP_HOG: begin needBus = (cpuState == ST_I) || (cpuState == ST_S);  cmdE = BC_GETH; end
      default: begin needBus = 1'b0;                                      cmdE = BC_NONE; end
    endcase

    unique case (opE)
      OP_RD:   cpuNext = needBus ? (shareIn ? ST_S : ST_E) : cpuState;
      OP_WR:   cpuNext = (cpuState == ST_H) ? ST_H : ST_M;
      OP_HOG:  cpuNext = ST_H;
      default: cpuNext = ST_I;
    endcase

    localOk = cpuValid && !needBus && !(snpValid && blkMatch);
    busOk   = cpuValid && needBus && busGnt && !nackIn;
    cpuDone = localOk || busOk;
    cpuHit  = localOk && (opE != OP_INV);
    wbOut   = localOk && (opE == OP_INV) && dirty;
    busReq  = cpuValid && needBus;
    busCmd  = busReq ? cmdE : BC_NONE;

    snpHit   = snpValid && (snpState != ST_I);
    nackOut  = snpHit && (snpState == ST_H);
    shareOut = snpHit && (snpState != ST_H);
    flushOut = snpHit && (snpState == ST_M);

    strb.cpuWe   = cpuDone;
    strb.cpuNext = cpuNext;
    strb.snpWe   = shareOut;
    strb.snpNext = (busCmd_t'(snpCmd) == BC_GETS) ? ST_S : ST_I;
  end
endmodule

// File: rtl/hogSnoopCtl.sv
module hogSnoopCtl
  import hogSnoopPkg::*;
#(
  parameter int NBLK = 4,
  parameter int BW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuValid,
  input  logic [1:0]    cpuOp,
  input  logic [BW-1:0] cpuBlk,
  output logic          cpuDone,
  output logic          cpuHit,
  output logic          wbOut,
  output logic          busReq,
  output logic [1:0]    busCmd,
  output logic [BW-1:0] busBlk,
  input  logic          busGnt,
  input  logic          shareIn,
  input  logic          nackIn,
  input  logic          snpValid,
  input  logic [1:0]    snpCmd,
  input  logic [BW-1:0] snpBlk,
  output logic          shareOut,
  output logic          flushOut,
  output logic          nackOut
);
  stStrobe_t strb;
  lineSt_t   cpuState, snpState;

  hogSnoopDp #(.NBLK(NBLK), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .cpuBlk(cpuBlk), .snpBlk(snpBlk),
    .strb(strb), .cpuState(cpuState), .snpState(snpState)
  );

  hogSnoopCtrl u_ctrl (
    .cpuValid(cpuValid), .cpuOp(cpuOp), .blkMatch(cpuBlk == snpBlk),
    .cpuState(cpuState), .snpValid(snpValid), .snpCmd(snpCmd),
    .snpState(snpState), .busGnt(busGnt), .shareIn(shareIn), .nackIn(nackIn),
    .strb(strb), .cpuDone(cpuDone), .cpuHit(cpuHit), .wbOut(wbOut),
    .busReq(busReq), .busCmd(busCmd), .shareOut(shareOut),
    .flushOut(flushOut), .nackOut(nackOut)
  );

  assign busBlk = cpuBlk;
endmodule

// File: rtl/hogSnoopChk.sv
module hogSnoopChk #(
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuValid,
  input logic [1:0]    cpuOp,
  input logic [BW-1:0] cpuBlk,
  input logic          cpuDone,
  input logic          wbOut,
  input logic          busReq,
  input logic          busGnt,
  input logic          nackIn,
  input logic          snpValid,
  input logic [BW-1:0] snpBlk,
  input logic          shareOut,
  input logic          flushOut,
  input logic          nackOut
);
  // R7
  nack_stalls_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && nackIn) |-> !cpuDone);

  // R2
  miss_needs_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |-> !cpuDone);

  // R8
  wb_only_on_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbOut |-> (cpuDone && cpuValid && cpuOp == 2'd3));

  // R7
  hog_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    nackOut |-> (!shareOut && !flushOut));

  // R5
  flush_from_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> (snpValid && shareOut));

  // R9
  same_blk_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && !busReq && snpValid && cpuBlk == snpBlk) |-> !cpuDone);
endmodule

bind hogSnoopCtl hogSnoopChk #(.BW(BW)) u_chk (.*);

// File: tb/hogSnoopCtl_tb.sv
module hogSnoopCtl_tb;
  timeunit 1ns; timeprecision 1ps;
  localparam int NC = 3, NBLK = 4, BW = 2, RUNCYC = 3000;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3, SH = 4;

  logic clk = 0, rstN = 0;
  always #5 clk = ~clk;

  logic [NC-1:0] cpuValid, cpuDone, cpuHit, wbOut, busReq, busGnt, shareIn, nackIn;
  logic [NC-1:0] snpValid, shareOut, flushOut, nackOut;
  logic [1:0]    cpuOp [NC];
  logic [1:0]    busCmd [NC];
  logic [1:0]    snpCmd [NC];
  logic [BW-1:0] cpuBlk [NC];
  logic [BW-1:0] busBlk [NC];
  logic [BW-1:0] snpBlk [NC];

  for (genvar i = 0; i < NC; i++) begin : g_c
    hogSnoopCtl #(.NBLK(NBLK), .BW(BW)) u_dut (
      .clk(clk), .rstN(rstN), .cpuValid(cpuValid[i]), .cpuOp(cpuOp[i]),
      .cpuBlk(cpuBlk[i]), .cpuDone(cpuDone[i]), .cpuHit(cpuHit[i]),
      .wbOut(wbOut[i]), .busReq(busReq[i]), .busCmd(busCmd[i]),
      .busBlk(busBlk[i]), .busGnt(busGnt[i]), .shareIn(shareIn[i]),
      .nackIn(nackIn[i]), .snpValid(snpValid[i]), .snpCmd(snpCmd[i]),
      .snpBlk(snpBlk[i]), .shareOut(shareOut[i]), .flushOut(flushOut[i]),
      .nackOut(nackOut[i])
    );
  end

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      shareIn[c] = |(shareOut & ~(NC'(1) << c));
      nackIn[c]  = |(nackOut  & ~(NC'(1) << c));
    end
  end

  int checks = 0, fails = 0;
  int st [NC][NBLK];
  bit pv [NC];
  int pop [NC], pblk [NC], page [NC];
  int qOp [NC][$];
  int qBlk [NC][$];
  int rr = 0, idleRun = 0;
  int nackSeen = 0, conflSeen = 0, wbSeen = 0, flushSeen = 0, hitSeen = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string opTag(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic push(int c, int op, int blk);
    qOp[c].push_back(op);
    qBlk[c].push_back(blk);
  endtask

  task automatic idle(int c, int n);
    for (int k = 0; k < n; k++) push(c, 4, 0);
  endtask

  initial begin
    // directed opening on block 1
    push(0, 0, 1);                                   // R2 fill E
    idle(1, 3); push(1, 0, 1);                       // R2 fill S, R5 share
    push(1, 1, 1);                                   // R3 upgrade, R6 invalidate
    idle(0, 8); push(0, 2, 1);                       // R4 hog read, R6 flush
    idle(0, 6); push(0, 3, 1);                       // R8 write back from H
    // block 2 silent moves, then R7 retry on block 1
    push(2, 0, 2); push(2, 1, 2); push(2, 2, 2);     // E, M (R3), H (R4)
    push(2, 0, 2); push(2, 3, 2);                    // hit on H, R8
    idle(2, 8); push(2, 0, 1);                       // refused while hogged (R7)
  end

  int g, gblk, gcmd;
  bit nackAny, shareAny;
  int need [NC], expCmd [NC];
  int nst [NC][NBLK];

  initial begin
    for (int c = 0; c < NC; c++) begin
      pv[c] = 0; page[c] = 0;
      for (int b = 0; b < NBLK; b++) st[c][b] = SI;
    end
    cpuValid = '0; busGnt = '0; snpValid = '0;
    for (int c = 0; c < NC; c++) begin
      cpuOp[c] = 0; cpuBlk[c] = 0; snpCmd[c] = 0; snpBlk[c] = 0;
    end
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1;
    #1;
    for (int c = 0; c < NC; c++) begin
      chk(cpuDone[c] == 0, "R1", "cpuDone after reset", cpuDone[c], 0);
      chk(busReq[c] == 0, "R1", "busReq after reset", busReq[c], 0);
    end

    for (int cyc = 0; cyc < RUNCYC; cyc++) begin
      @(negedge clk);
      // schedule commands
      for (int c = 0; c < NC; c++) begin
        if (pv[c] && page[c] >= 12) pv[c] = 0;
        if (!pv[c]) begin
          if (qOp[c].size() > 0) begin
            int o, b;
            o = qOp[c].pop_front(); b = qBlk[c].pop_front();
            if (o != 4) begin pv[c] = 1; pop[c] = o; pblk[c] = b; page[c] = 0; end
          end else if (cyc >= 80 && $urandom_range(0, 1) == 1) begin
            int r;
            r = $urandom_range(0, 9);
            pop[c] = (r < 4) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : 3;
            pblk[c] = $urandom_range(0, NBLK - 1);
            pv[c] = 1; page[c] = 0;
          end
        end
        cpuValid[c] = pv[c];
        cpuOp[c] = 2'(pop[c]);
        cpuBlk[c] = BW'(pblk[c]);
      end
      // model: bus need and grant
      g = -1;
      for (int c = 0; c < NC; c++) begin
        int s;
        s = st[c][pblk[c]];
        case (pop[c])
          0: begin need[c] = (s == SI);             expCmd[c] = 0; end
          1: begin need[c] = (s == SI || s == SS);  expCmd[c] = 1; end
          2: begin need[c] = (s == SI || s == SS);  expCmd[c] = 2; end
          default: begin need[c] = 0;               expCmd[c] = 3; end
        endcase
        if (!pv[c]) need[c] = 0;
      end
      for (int k = 0; k < NC; k++) begin
        int c;
        c = (rr + k) % NC;
        if (g < 0 && need[c] != 0) g = c;
      end
      gblk = (g >= 0) ? pblk[g] : 0;
      gcmd = (g >= 0) ? expCmd[g] : 0;
      nackAny = 0; shareAny = 0;
      for (int c = 0; c < NC; c++) begin
        busGnt[c] = (c == g);
        snpValid[c] = (g >= 0) && (c != g);
        snpCmd[c] = 2'(gcmd);
        snpBlk[c] = BW'(gblk);
        if (g >= 0 && c != g) begin
          if (st[c][gblk] == SH) nackAny = 1;
          else if (st[c][gblk] != SI) shareAny = 1;
        end
      end
      #2;
      nst = st;
      // snoop side
      for (int c = 0; c < NC; c++) begin
        int s; bit eN, eS, eF; string t;
        s = st[c][gblk];
        eN = 0; eS = 0; eF = 0;
        if (g >= 0 && c != g && s != SI) begin
          eN = (s == SH); eS = (s != SH); eF = (s == SM);
          if (eS) nst[c][gblk] = (gcmd == 0) ? SS : SI;
        end
        t = (gcmd == 0) ? "R5" : "R6";
        if (eN) nackSeen++;
        if (eF) flushSeen++;
        chk(nackOut[c] == eN, "R7", "nackOut", nackOut[c], eN);
        chk(shareOut[c] == eS, t, "shareOut", shareOut[c], eS);
        chk(flushOut[c] == eF, t, "flushOut", flushOut[c], eF);
      end
      // processor side
      for (int c = 0; c < NC; c++) begin
        int s; bit eD, eH, eW, confl; string t;
        s = st[c][pblk[c]];
        confl = (g >= 0) && (c != g) && (pblk[c] == gblk);
        t = opTag(pop[c]);
        eD = 0; eH = 0; eW = 0;
        if (pv[c]) begin
          if (need[c] != 0) begin
            eD = (c == g) && !nackAny;
            if (c == g && nackAny) t = "R7";
          end else begin
            eD = !confl;
            if (confl) begin t = "R9"; conflSeen++; end
            eH = eD && pop[c] != 3;
            eW = eD && pop[c] == 3 && (s == SM || s == SH);
          end
        end
        chk(busReq[c] == (need[c] != 0), t, "busReq", busReq[c], need[c]);
        if (need[c] != 0) begin
          chk(busCmd[c] == 2'(expCmd[c]), t, "busCmd", busCmd[c], expCmd[c]);
          chk(busBlk[c] == BW'(pblk[c]), "R2", "busBlk", busBlk[c], pblk[c]);
        end
        chk(cpuDone[c] == eD, t, "cpuDone", cpuDone[c], eD);
        chk(cpuHit[c] == eH, t, "cpuHit", cpuHit[c], eH);
        chk(wbOut[c] == eW, "R8", "wbOut", wbOut[c], eW);
        if (eH) hitSeen++;
        if (eW) wbSeen++;
        if (eD) begin
          case (pop[c])
            0: nst[c][pblk[c]] = (s == SI) ? (shareAny ? SS : SE) : s;
            1: nst[c][pblk[c]] = (s == SH) ? SH : SM;
            2: nst[c][pblk[c]] = SH;
            default: nst[c][pblk[c]] = SI;
          endcase
          pv[c] = 0;
          idleRun = 0;
        end else if (pv[c]) begin
          page[c]++;
        end
      end
      st = nst;
      if (g >= 0) rr = (g + 1) % NC;
      idleRun++;
      if (idleRun > 300) begin
        chk(0, "R7", "no progress", idleRun, 0);
        break;
      end
    end

    chk(nackSeen > 0, "R7", "refusals seen", nackSeen, 1);
    chk(conflSeen > 0, "R9", "same-block stalls seen", conflSeen, 1);
    chk(wbSeen > 0, "R8", "write backs seen", wbSeen, 1);
    chk(flushSeen > 0, "R6", "flushes seen", flushSeen, 1);
    chk(hitSeen > 0, "R2", "local hits seen", hitSeen, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule